// File: doc/BRIEF.md
# Paired Lookup Memory with Partner Write Mirroring

This block holds the two private lookup memories of a pair of processor cores, one even and one odd. Each core reaches its own memory through a single read/write access port and also has a burst write port, driven by a transfer engine that lives outside this block. A synchronous read returns data one cycle after the request.

Each memory has a sharing enable that belongs to its owner. While a memory's sharing enable is high, every write that the partner core commits to its own memory, from either the access port or the burst port, is also applied to this memory at the same address. This holds over the whole address range. The writer has no control over this. Only the receiving side decides, by raising or dropping its enable. Accesses that land in a memory at one of its four highest addresses pulse an event flag for the owning core. If a local write and a mirrored write hit the same word in the same cycle, the local write is kept and a collision pulse is raised.

Top module: `lutp_pair`

## Requirements
- R1: With both sharing enables low, a write by core c changes only memory c. Reading memory c returns the last word written there by core c.
- R2: While share_en[m] is 1, every write committed by core 1-m to memory 1-m is also written to memory m at the same address with the same data.
- R3: The writer's own share_en bit has no effect on where its writes go. After share_en[m] returns to 0, writes by core 1-m no longer change memory m.
- R4: Mirroring applies to every address from 0 to 511.
- R5: A burst write (bst_en[c]=1) is written to memory c and is mirrored exactly like an access-port write.
- R6: evt[m] bit k pulses for one cycle, in the cycle after any of these lands in memory m at address 508+k: a read by core m, a write committed by core m, or a mirrored write. Several bits can be set together. evt[m] is 0 after a cycle with no such access.
- R7: If core m's committed write and a mirrored write target the same address of memory m in one cycle, memory m keeps core m's data. coll[m] is 1 in the next cycle and is 0 otherwise.
- R8: A read is acc_en=1 with acc_we=0. When the read and a write that lands in the same memory hit the same address in the same cycle, the read returns the newly written data (write-first).
- R9: If acc_en[c] and acc_we[c] are both 1 in the same cycle as bst_en[c], the access-port write is committed and the burst write is dropped, in both memories.
- R10: After reset, rd_data, evt and coll are all 0.
- R11: rd_data[c] changes only in the cycle after a read by core c, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_en | input | 2 | Per-memory enable to receive the partner's writes |
| acc_en | input | 2 | Per-core access request |
| acc_we | input | 2 | Per-core write select (1 = write, 0 = read) |
| acc_addr | input | 2x9 | Per-core access address |
| acc_wdata | input | 2x32 | Per-core access write data |
| bst_en | input | 2 | Per-core burst write strobe |
| bst_addr | input | 2x9 | Per-core burst write address |
| bst_wdata | input | 2x32 | Per-core burst write data |
| rd_data | output | 2x32 | Per-core registered read data |
| evt | output | 2x4 | Per-memory top-address event pulses, bit k for address 508+k |
| coll | output | 2 | Per-memory collision pulse (local and mirrored write on one word) |

## Verification
The assertions check on every cycle that:
- a mirrored write lands in the receiving memory;
- the local write wins a same-word collision and the collision pulse follows it;
- a read that meets a local write on the same word returns the new data;
- the event vector is clear after an idle cycle;
- read data holds when there is no read.

Some behaviours can only be shown by the bench's scenarios:
- that the writer's own enable is irrelevant;
- that mirroring stops once the receiver drops its enable;
- that the full address range is covered;
- that a burst write yields to an access-port write;
- the exact event bit that each top address produces.

The bench shows these by sweeping all addresses and every combination of enables and strobes against a model of both memories.

// File: rtl/lutp_pkg.sv
package lutp_pkg;
    localparam int unsigned LUTP_NCORE = 2;
    localparam int unsigned LUTP_AW    = 9;
    localparam int unsigned LUTP_DW    = 32;
    localparam int unsigned LUTP_NEVT  = 4;

    // first address of the event window at the top of a memory
    function automatic int unsigned lutp_evt_base(input int unsigned aw,
                                                  input int unsigned nevt);
        return (32'd1 << aw) - nevt;
    endfunction
endpackage

// File: rtl/lutp_wsel.sv
// Picks the write a core commits this cycle: the access port wins over burst.
module lutp_wsel #(
    parameter int unsigned ADDR_W = lutp_pkg::LUTP_AW,
    parameter int unsigned DATA_W = lutp_pkg::LUTP_DW
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              bst_en,
    input  logic [ADDR_W-1:0] bst_addr,
    input  logic [DATA_W-1:0] bst_wdata,
    output logic              w_en,
    output logic [ADDR_W-1:0] w_addr,
    output logic [DATA_W-1:0] w_data
);
    logic acc_wr;

    always_comb begin
        acc_wr = acc_en && acc_we;
        w_en   = acc_wr || bst_en;
        if (acc_wr) begin
            w_addr = acc_addr;
            w_data = acc_wdata;
        end else begin
            w_addr = bst_addr;
            w_data = bst_wdata;
        end
    end
endmodule

// File: rtl/lutp_tophit.sv
// One-hot decode of an access into the event window at the top of a memory.
module lutp_tophit #(
    parameter int unsigned ADDR_W = lutp_pkg::LUTP_AW,
    parameter int unsigned NEVT   = lutp_pkg::LUTP_NEVT
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NEVT-1:0]   hit
);
    localparam int unsigned BASE = lutp_pkg::lutp_evt_base(ADDR_W, NEVT);

    for (genvar k = 0; k < NEVT; k++) begin : g_slot
        assign hit[k] = en && (addr == ADDR_W'(BASE + k));
    end
endmodule

// File: rtl/lutp_bank.sv
// One lookup memory: local write, optional mirrored partner write, one read.
module lutp_bank #(
    parameter int unsigned ADDR_W = lutp_pkg::LUTP_AW,
    parameter int unsigned DATA_W = lutp_pkg::LUTP_DW,
    parameter int unsigned NEVT   = lutp_pkg::LUTP_NEVT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              share,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_data,
    input  logic              par_we,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic [DATA_W-1:0] par_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NEVT-1:0]   evt,
    output logic              coll
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic [NEVT-1:0]   evt;
        logic              coll;
    } bank_st_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    bank_st_t          st_d, st_q;
    logic              mir_we, hit_coll, mir_commit;
    logic [NEVT-1:0]   h_rd, h_loc, h_mir;

    assign mir_we     = share && par_we;
    assign hit_coll   = loc_we && mir_we && (loc_addr == par_addr);
    assign mir_commit = mir_we && !hit_coll;

    lutp_tophit #(.ADDR_W(ADDR_W), .NEVT(NEVT)) u_hit_rd (
        .en(rd_en), .addr(rd_addr), .hit(h_rd));
    lutp_tophit #(.ADDR_W(ADDR_W), .NEVT(NEVT)) u_hit_loc (
        .en(loc_we), .addr(loc_addr), .hit(h_loc));
    lutp_tophit #(.ADDR_W(ADDR_W), .NEVT(NEVT)) u_hit_mir (
        .en(mir_we), .addr(par_addr), .hit(h_mir));

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (loc_we && (loc_addr == rd_addr)) begin
                st_d.rd_data = loc_data;
            end else if (mir_commit && (par_addr == rd_addr)) begin
                st_d.rd_data = par_data;
            end else begin
                st_d.rd_data = mem_q[rd_addr];
            end
        end
        st_d.evt  = h_rd | h_loc | h_mir;
        st_d.coll = hit_coll;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mir_commit) begin
            mem_q[par_addr] <= par_data;
        end
        if (loc_we) begin
            mem_q[loc_addr] <= loc_data;
        end
    end

    assign rd_data = st_q.rd_data;
    assign evt     = st_q.evt;
    assign coll    = st_q.coll;

    AST_MIRROR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_we && !(loc_we && (loc_addr == par_addr)))
        |=> (mem_q[$past(par_addr)] == $past(par_data))); // R2
    AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_we && mir_we && (loc_addr == par_addr))
        |=> (coll && (mem_q[$past(loc_addr)] == $past(loc_data)))); // R7
    AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_we && mir_we) |=> !coll); // R7
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && loc_we && (loc_addr == rd_addr))
        |=> (rd_data == $past(loc_data))); // R8
    AST_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !loc_we && !mir_we) |=> (evt == '0)); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11
endmodule

// File: rtl/lutp_pair.sv
module lutp_pair #(
    parameter int unsigned ADDR_W = lutp_pkg::LUTP_AW,
    parameter int unsigned DATA_W = lutp_pkg::LUTP_DW,
    parameter int unsigned NEVT   = lutp_pkg::LUTP_NEVT
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [lutp_pkg::LUTP_NCORE-1:0]              share_en,
    input  logic [lutp_pkg::LUTP_NCORE-1:0]              acc_en,
    input  logic [lutp_pkg::LUTP_NCORE-1:0]              acc_we,
    input  logic [lutp_pkg::LUTP_NCORE-1:0][ADDR_W-1:0]  acc_addr,
    input  logic [lutp_pkg::LUTP_NCORE-1:0][DATA_W-1:0]  acc_wdata,
    input  logic [lutp_pkg::LUTP_NCORE-1:0]              bst_en,
    input  logic [lutp_pkg::LUTP_NCORE-1:0][ADDR_W-1:0]  bst_addr,
    input  logic [lutp_pkg::LUTP_NCORE-1:0][DATA_W-1:0]  bst_wdata,
    output logic [lutp_pkg::LUTP_NCORE-1:0][DATA_W-1:0]  rd_data,
    output logic [lutp_pkg::LUTP_NCORE-1:0][NEVT-1:0]    evt,
    output logic [lutp_pkg::LUTP_NCORE-1:0]              coll
);
    localparam int unsigned NCORE = lutp_pkg::LUTP_NCORE;

    logic [NCORE-1:0]             w_en;
    logic [NCORE-1:0][ADDR_W-1:0] w_addr;
    logic [NCORE-1:0][DATA_W-1:0] w_data;
    logic [NCORE-1:0]             rd_en;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        localparam int unsigned P = c ^ 1;

        assign rd_en[c] = acc_en[c] && !acc_we[c];

        lutp_wsel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wsel (
            .acc_en   (acc_en[c]),
            .acc_we   (acc_we[c]),
            .acc_addr (acc_addr[c]),
            .acc_wdata(acc_wdata[c]),
            .bst_en   (bst_en[c]),
            .bst_addr (bst_addr[c]),
            .bst_wdata(bst_wdata[c]),
            .w_en     (w_en[c]),
            .w_addr   (w_addr[c]),
            .w_data   (w_data[c])
        );

        lutp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NEVT(NEVT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .share   (share_en[c]),
            .loc_we  (w_en[c]),
            .loc_addr(w_addr[c]),
            .loc_data(w_data[c]),
            .par_we  (w_en[P]),
            .par_addr(w_addr[P]),
            .par_data(w_data[P]),
            .rd_en   (rd_en[c]),
            .rd_addr (acc_addr[c]),
            .rd_data (rd_data[c]),
            .evt     (evt[c]),
            .coll    (coll[c])
        );

        AST_BURST_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en[c] && acc_we[c] && bst_en[c])
            |-> (w_addr[c] == acc_addr[c] && w_data[c] == acc_wdata[c])); // R9
    end
endmodule

// File: tb/lutp_pair_tb_top.sv
module lutp_pair_tb_top;
    localparam int PERIOD = 10;
    localparam int AW = 9;
    localparam int DW = 32;
    localparam int DEPTH = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]          share_en = '0, acc_en = '0, acc_we = '0, bst_en = '0;
    logic [1:0][AW-1:0]  acc_addr = '0, bst_addr = '0;
    logic [1:0][DW-1:0]  acc_wdata = '0, bst_wdata = '0;
    logic [1:0][DW-1:0]  rd_data;
    logic [1:0][3:0]     evt;
    logic [1:0]          coll;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [DW-1:0] model [2][DEPTH];
    logic [DW-1:0] exp_rd [2];

    always #(PERIOD/2) clk = ~clk;

    lutp_pair dut_i (
        .clk(clk), .rst_n(rst_n), .share_en(share_en), .acc_en(acc_en),
        .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .bst_en(bst_en), .bst_addr(bst_addr), .bst_wdata(bst_wdata),
        .rd_data(rd_data), .evt(evt), .coll(coll)
    );

    function automatic logic [3:0] hits(input logic v, input logic [AW-1:0] a);
        if (v && a >= 9'd508) return 4'(1 << (a - 9'd508));
        return 4'b0;
    endfunction

    task automatic idle();
        acc_en = '0; acc_we = '0; bst_en = '0;
    endtask

    // one cycle: predict, clock, compare (inputs already driven)
    task automatic cyc(input string tag);
        logic          ew [2];
        logic [AW-1:0] ea [2];
        logic [DW-1:0] ed [2];
        logic [3:0]    ne [2];
        logic          nc [2];
        for (int c = 0; c < 2; c++) begin
            logic cw;
            cw = acc_en[c] && acc_we[c];
            ew[c] = cw || bst_en[c];
            ea[c] = cw ? acc_addr[c] : bst_addr[c];
            ed[c] = cw ? acc_wdata[c] : bst_wdata[c];
        end
        for (int m = 0; m < 2; m++) begin
            int p;
            logic mir, loc, rd;
            p   = 1 - m;
            mir = share_en[m] && ew[p];
            loc = ew[m];
            rd  = acc_en[m] && !acc_we[m];
            nc[m] = loc && mir && (ea[m] == ea[p]);
            if (rd) begin
                if (loc && ea[m] == acc_addr[m]) exp_rd[m] = ed[m];
                else if (mir && !nc[m] && ea[p] == acc_addr[m]) exp_rd[m] = ed[p];
                else exp_rd[m] = model[m][acc_addr[m]];
            end
            ne[m] = hits(rd, acc_addr[m]) | hits(loc, ea[m]) | hits(mir, ea[p]);
            if (mir && !nc[m]) model[m][ea[p]] = ed[p];
            if (loc) model[m][ea[m]] = ed[m];
        end
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (rd_data[m] !== exp_rd[m] || evt[m] !== ne[m] || coll[m] !== nc[m]) begin
                failures++;
                $display("FAIL %s mem%0d: rd=%h evt=%b coll=%b expected rd=%h evt=%b coll=%b",
                         tag, m, rd_data[m], evt[m], coll[m], exp_rd[m], ne[m], nc[m]);
            end
        end
    endtask

    task automatic acc(input int c, input logic we, input int a, input logic [DW-1:0] d);
        acc_en[c] = 1'b1; acc_we[c] = we; acc_addr[c] = AW'(a); acc_wdata[c] = d;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        exp_rd[0] = '0; exp_rd[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (rd_data[m] !== '0 || evt[m] !== '0 || coll[m] !== 1'b0) begin
                failures++;
                $display("FAIL R10 mem%0d after reset: rd=%h evt=%b coll=%b expected 0 0 0",
                         m, rd_data[m], evt[m], coll[m]);
            end
        end

        // R1: fill both memories privately
        for (int i = 0; i < DEPTH; i++) begin
            idle(); acc(0, 1, i, 32'h1000_0000 | i); acc(1, 1, i, 32'h2000_0000 | i);
            cyc("R1");
        end
        // R1: core1 overwrites while core0 reads the same word, no sharing
        for (int i = 0; i < DEPTH; i++) begin
            idle(); acc(0, 0, i, '0); acc(1, 1, i, 32'h2100_0000 | i);
            cyc("R1");
        end
        // R2/R4/R8: memory0 receives core1 writes across the whole range;
        // core0 reads the same word in the same cycle (write-first via mirror)
        share_en = 2'b01;
        for (int i = 0; i < DEPTH; i++) begin
            idle(); acc(1, 1, i, 32'h3000_0000 ^ (i * 32'h9E37)); acc(0, 0, i, '0);
            cyc("R4");
        end
        for (int i = 0; i < DEPTH; i++) begin
            idle(); acc(0, 0, i, '0); acc(1, 0, DEPTH - 1 - i, '0);
            cyc("R2");
        end
        // R11: idle and write-only cycles keep read data
        idle(); cyc("R11");
        acc(0, 1, 5, 32'hDEAD_0005); cyc("R11");
        idle(); cyc("R11");
        // R3: writer's own enable irrelevant; receiver off stops mirroring
        share_en = 2'b10;
        for (int i = 0; i < 64; i++) begin
            idle(); acc(1, 1, i * 8, 32'h4000_0000 | i); acc(0, 0, i * 8, '0);
            cyc("R3");
        end
        share_en = 2'b00;
        for (int i = 0; i < 64; i++) begin
            idle(); acc(0, 1, i * 8 + 1, 32'h4100_0000 | i); acc(1, 0, i * 8 + 1, '0);
            cyc("R3");
        end
        // R5: burst writes mirrored both ways
        share_en = 2'b11;
        for (int i = 0; i < 128; i++) begin
            idle();
            bst_en[i % 2] = 1'b1; bst_addr[i % 2] = AW'(384 + i);
            bst_wdata[i % 2] = 32'h5000_0000 | i;
            acc(1 - (i % 2), 0, 384 + i, '0);
            cyc("R5");
        end
        for (int i = 0; i < 128; i++) begin
            idle(); acc(0, 0, 384 + i, '0); acc(1, 0, 384 + i, '0);
            cyc("R5");
        end
        // R9: access write beats burst on the same core
        for (int i = 0; i < 16; i++) begin
            idle(); acc(0, 1, 100 + i, 32'h6000_0000 | i);
            bst_en[0] = 1'b1; bst_addr[0] = AW'(200 + i); bst_wdata[0] = 32'h6100_0000 | i;
            cyc("R9");
            idle(); acc(0, 0, 200 + i, '0); acc(1, 0, 200 + i, '0);
            cyc("R9");
        end
        // R6: event sweep over the top region, every core and sharing mode
        for (int s = 0; s < 4; s++) begin
            share_en = 2'(s);
            for (int a = 500; a < DEPTH; a++) begin
                idle(); acc(0, 0, a, '0); cyc("R6");
                idle(); acc(1, 1, a, 32'h7000_0000 | a); cyc("R6");
            end
        end
        // R7: same-word collisions under all sharing modes
        for (int s = 0; s < 4; s++) begin
            share_en = 2'(s);
            for (int a = 0; a < 8; a++) begin
                idle(); acc(0, 1, a * 70, 32'h8000_0000 | a); acc(1, 1, a * 70, 32'h8100_0000 | a);
                cyc("R7");
                idle(); acc(0, 0, a * 70, '0); acc(1, 0, a * 70, '0);
                cyc("R7");
            end
        end
        // R6/R7/R8/R9: exhaustive strobe, enable and address combinations
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] b;
            b = 12'(v);
            share_en = b[1:0]; acc_en = b[3:2]; acc_we = b[5:4]; bst_en = b[7:6];
            acc_addr[0] = b[8] ? 9'd511 : 9'd510;
            acc_addr[1] = b[9] ? 9'd511 : 9'd510;
            bst_addr[0] = b[10] ? 9'd511 : 9'd510;
            bst_addr[1] = b[11] ? 9'd511 : 9'd510;
            acc_wdata[0] = 32'hA000_0000 | v; acc_wdata[1] = 32'hB000_0000 | v;
            bst_wdata[0] = 32'hC000_0000 | v; bst_wdata[1] = 32'hD000_0000 | v;
            cyc("R6_R7_R8_R9");
        end
        idle(); share_en = '0;
        acc(0, 0, 510, '0); acc(1, 0, 511, '0); cyc("R8");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule